// File: doc/BRIEF.md
# Multiply-Add Extended Unit

This block takes two unsigned 64-bit factors and a 64-bit addend. It produces the complete 128-bit value `op_a * op_b + op_c` and returns it as two 64-bit words: the low word on `res_lo` and the high word on `res_hi`. The product is never truncated. The addend enters with its upper half at zero, so callers receive the carry out of the low word in the high word.

A caller waits until `idle` is high, then raises `start` for one cycle with the three operands on the inputs. The unit multiplies with radix-2^K shift-and-add and retires `K` multiplier bits per clock. The accumulator is seeded with the zero-extended addend, so the addition costs no extra cycle. With the default `K = 4`, `done` rises for a single cycle 16 clocks after the accepting edge. Both result words then hold until the next accepted `start`. The unit produces no flags and no status beyond `idle` and `done`.

Top module: `mae_unit`

## Requirements
- R1: The product of `op_a` and `op_b` is formed as an unsigned 128-bit value, with no bits dropped.
- R2: `op_c` is added with bits 127..64 equal to zero, so it is never sign-extended.
- R3: Bits 63..0 of the 128-bit sum appear on `res_lo`.
- R4: Bits 127..64 of the 128-bit sum appear on `res_hi`.
- R5: `start` is accepted only on a rising clock edge where `idle` is 1. A `start` seen while `idle` is 0 changes neither the pending result nor the number of `done` pulses.
- R6: `done` is high for exactly one cycle, `W/K` clock edges after the accepting edge (16 by default). `idle` is 0 from the accepting edge until the edge that raises `done`.
- R7: `res_lo` and `res_hi` keep their values from the `done` pulse until the next accepted `start`, whatever the operand inputs do.
- R8: While `rst_n` is 0, `done` is 0 and `idle` is 1. This takes effect at once, even in the middle of an operation, and an interrupted operation produces no `done`.
- R9: The 128-bit accumulator never carries out of bit 127, even with all three operands at their maximum value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| start | input | 1 | Request: sample the operands and begin |
| op_a | input | 64 | First unsigned factor |
| op_b | input | 64 | Second unsigned factor |
| op_c | input | 64 | Addend, zero-extended to 128 bits |
| idle | output | 1 | High when a start can be accepted |
| done | output | 1 | One-cycle pulse when both result words are valid |
| res_lo | output | 64 | Bits 63..0 of the sum |
| res_hi | output | 64 | Bits 127..64 of the sum |

## Verification
A result is due on the 16th rising edge after the edge that accepts `start` (`W/K` in general), and it stays due until the next accepted start. The driver records the number of that accepting edge together with the 128-bit expected value. The monitor compares both words in the half cycle after `done` rises, and it requires the distance between the two edges to be exactly 16. A `done` that arrives with nothing outstanding counts as a miscompare. The hold checks sample the result ports at falling edges over several idle cycles after the last pulse, while the operand inputs are changed.

// File: rtl/mae_pkg.sv
package mae_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mae_state_e;

endpackage

// File: rtl/mae_ctrl.sv
module mae_ctrl
  import mae_pkg::*;
#(
  parameter int STEPS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic idle,
  output logic load,
  output logic step,
  output logic done
);

  localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CW-1:0] LASTC = CW'(STEPS - 1);

  mae_state_e     state_q, state_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           done_q, done_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_RUN;
          cnt_d   = '0;
        end
      end
      ST_RUN: begin
        if (cnt_q == LASTC) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign idle = (state_q == ST_IDLE);
  assign load = idle && start;
  assign step = (state_q == ST_RUN);
  assign done = done_q;

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (state_q == ST_IDLE));

  // R5
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && cnt_q != LASTC) |=>
      (state_q == ST_RUN && cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/mae_ppgen.sv
module mae_ppgen #(
  parameter int W2 = 128,
  parameter int K  = 4
) (
  input  logic [W2-1:0] mc,
  input  logic [K-1:0]  digit,
  output logic [W2-1:0] pp
);

  logic [W2-1:0] rows [K];

  for (genvar j = 0; j < K; j++) begin : g_row
    assign rows[j] = digit[j] ? (mc << j) : '0;
  end

  always_comb begin
    pp = '0;
    for (int j = 0; j < K; j++) begin
      pp = pp + rows[j];
    end
  end

endmodule

// File: rtl/mae_datapath.sv
module mae_datapath #(
  parameter int W = 64,
  parameter int K = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi
);

  localparam int W2 = 2 * W;

  logic [W2-1:0] acc_q, acc_d;
  logic [W2-1:0] mc_q, mc_d;
  logic [W-1:0]  mp_q, mp_d;
  logic [W2-1:0] pp;
  logic [W2:0]   sum_wide;
  logic          en;

  mae_ppgen #(.W2(W2), .K(K)) u_ppgen (
    .mc    (mc_q),
    .digit (mp_q[K-1:0]),
    .pp    (pp)
  );

  assign sum_wide = {1'b0, acc_q} + {1'b0, pp};
  assign en       = load || step;

  always_comb begin
    acc_d = acc_q;
    mc_d  = mc_q;
    mp_d  = mp_q;
    if (load) begin
      acc_d = {{W{1'b0}}, c};
      mc_d  = {{W{1'b0}}, a};
      mp_d  = b;
    end else if (step) begin
      acc_d = sum_wide[W2-1:0];
      mc_d  = mc_q << K;
      mp_d  = mp_q >> K;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      mc_q  <= '0;
      mp_q  <= '0;
    end else if (en) begin
      acc_q <= acc_d;
      mc_q  <= mc_d;
      mp_q  <= mp_d;
    end
  end

  assign lo = acc_q[W-1:0];
  assign hi = acc_q[W2-1:W];

  // R2
  zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (acc_q[W2-1:W] == '0));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !sum_wide[W2]);

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(acc_q));

endmodule

// File: rtl/mae_unit.sv
module mae_unit #(
  parameter int W = 64,
  parameter int K = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [W-1:0] op_c,
  output logic         idle,
  output logic         done,
  output logic [W-1:0] res_lo,
  output logic [W-1:0] res_hi
);

  localparam int STEPS = W / K;

  logic load, step;

  mae_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .idle  (idle),
    .load  (load),
    .step  (step),
    .done  (done)
  );

  mae_datapath #(.W(W), .K(K)) u_dp (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .step  (step),
    .a     (op_a),
    .b     (op_b),
    .c     (op_c),
    .lo    (res_lo),
    .hi    (res_hi)
  );

endmodule

// File: tb/mae_unit_test.sv
`timescale 1ns/1ps
module mae_unit_test;

  localparam int W     = 64;
  localparam int STEPS = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0, op_c = '0;
  logic         idle, done;
  logic [W-1:0] res_lo, res_hi;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  logic [2*W-1:0] exp_q[$];
  int             acc_edge_q[$];
  logic [W-1:0]   last_lo = '0, last_hi = '0;

  mae_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .op_a(op_a), .op_b(op_b), .op_c(op_c),
    .idle(idle), .done(done), .res_lo(res_lo), .res_hi(res_hi)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req,
                     input logic [2*W-1:0] act, input logic [2*W-1:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [W-1:0] c);
    while (!idle) @(negedge clk);
    start = 1'b1;
    op_a = a; op_b = b; op_c = c;
    exp_q.push_back(128'(a) * 128'(b) + 128'(c));
    acc_edge_q.push_back(cyc + 1);
    @(negedge clk);
    start = 1'b0;
    op_a = {$urandom, $urandom};
    op_b = {$urandom, $urandom};
    op_c = {$urandom, $urandom};
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || !idle) @(negedge clk);
  endtask

  // Monitor: scoreboard compare (R1..R4, R6, R9)
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5/R6 unexpected done", 128'(1), 128'(0));
      end else begin
        logic [2*W-1:0] e;
        int ae;
        e  = exp_q.pop_front();
        ae = acc_edge_q.pop_front();
        chk(res_lo == e[W-1:0], "R3 R1 R2 R9 low word", 128'(res_lo), 128'(e[W-1:0]));
        chk(res_hi == e[2*W-1:W], "R4 R1 R2 R9 high word", 128'(res_hi), 128'(e[2*W-1:W]));
        chk((cyc - ae) == STEPS, "R6 latency", 128'(cyc - ae), 128'(STEPS));
        last_lo = res_lo;
        last_hi = res_hi;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(done == 1'b0, "R8 done in reset", 128'(done), 128'(0));
    chk(idle == 1'b1, "R8 idle in reset", 128'(idle), 128'(1));
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners: R1 R2 R9
    drive('0, '0, '0);
    drive('1, '1, '1);
    drive('1, '1, '0);
    drive('0, '0, '1);
    drive(64'h1, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF);
    drive(64'h8000_0000_0000_0000, 64'h2, 64'h0);
    drive(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 64'h1);
    drive(64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 64'hDEAD_BEEF_CAFE_F00D);
    drain();

    // R7 hold while inputs move
    for (int i = 0; i < 6; i++) begin
      op_a = {$urandom, $urandom};
      op_c = {$urandom, $urandom};
      @(negedge clk);
      chk(res_lo == last_lo, "R7 low held", 128'(res_lo), 128'(last_lo));
      chk(res_hi == last_hi, "R7 high held", 128'(res_hi), 128'(last_hi));
    end

    // R5 start while busy is ignored
    drive(64'h0000_0000_0000_0003, 64'h0000_0000_0000_0005, 64'h7);
    repeat (4) @(negedge clk);
    chk(idle == 1'b0, "R6 busy during run", 128'(idle), 128'(0));
    start = 1'b1;
    op_a = '1; op_b = '1; op_c = '1;
    @(negedge clk);
    start = 1'b0;
    drain();
    repeat (STEPS + 4) @(negedge clk);
    chk(res_lo == 64'd22, "R5 busy start ignored", 128'(res_lo), 128'(22));

    // random vectors, back-to-back
    for (int i = 0; i < 40; i++) begin
      drive({$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom});
    end
    drain();

    // R8 asynchronous reset mid-operation
    drive(64'h55, 64'h66, 64'h77);
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    #0.5;
    chk(idle == 1'b1, "R8 idle after async reset", 128'(idle), 128'(1));
    chk(done == 1'b0, "R8 done after async reset", 128'(done), 128'(0));
    exp_q.delete();
    acc_edge_q.delete();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (STEPS + 3) @(negedge clk);

    drive(64'hFFFF_FFFF_0000_0001, 64'h0000_0001_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    drain();
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule